// File: doc/BRIEF.md
# Multi-Mode 32-bit Timer

This block is a general-purpose timer built around one 32-bit up-counter that serves three modes. In generation mode it produces a periodic pulse on its pin: the pin goes high at the start of each period, falls once the count passes a programmed width, and the counter restarts when it reaches a programmed period. In capture mode it measures an incoming waveform. It counts system clocks, records the count at each leading edge as the period and at each trailing edge as the high or low time, and restarts on every leading edge. In event-counting mode it advances on the chosen edge of the pin and wraps once a programmed number of edges have been seen.

Software reaches the block over a narrow bus whose data width is half the counter width. This is 16 bits by default. Reads and writes of the double-width registers are made atomic through a shared read snapshot and a shared write staging half. Every counter restart sets a sticky event flag, and every counter wrap past all-ones sets a sticky overflow flag. Both flags are cleared by writing one to them. A single interrupt request is raised while either flag is set and interrupts are enabled.

The timer pin and the alternate clock input are asynchronous to the system clock. Each passes through a two-stage synchroniser before edge detection, so each phase of an input waveform must last at least one system clock.

Top module: `gp_timer`

## Requirements
- R1: After reset the control word, status, period, width and counter all read zero, and `timerOut` and `irq` are low.
- R2: Writing the control word (address 0) with the enable bit 0 set while it was clear loads the counter: with 1 if the mode field (bits 2:1) selects generation (01), otherwise with 0. Writes to the counter addresses (6 and 7) have no effect.
- R3: In generation mode the counter advances on every system clock. When control bit 5 is set it advances only on rising edges of the synchronised alternate clock. On an advance with the count equal to the period, the counter goes to 1 and the event flag is set. `timerOut` is high exactly while generation mode is enabled and the count is at most the width.
- R4: In capture mode (10) the counter advances on every system clock. A leading edge of the pin copies the count into the period register, sets the counter to 1 and sets the event flag. A trailing edge copies the count into the width register. Leading means rising when control bit 4 is 0 and falling when it is 1.
- R5: In event-counting mode (11) the counter advances only on the selected edge of the pin: rising when bit 4 is 0, falling when it is 1. When the advanced value would equal the period, the counter goes to 0 instead and the event flag is set.
- R6: An advance from all-ones wraps the counter to 0 and sets the overflow flag.
- R7: The status word (address 1) holds the event flag in bit 0 and the overflow flag in bit 1. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. `irq` is high exactly while control bit 3 is set and either flag is set.
- R8: The pin and the alternate clock pass through two flip-flops before edge detection. An input edge first changes the counter two clock edges after the edge that samples it.
- R9: Reading a low half (address 2 period, 4 width, 6 counter) returns it directly and copies that register's high half into a shared snapshot. Reading any high half (3, 5, 7) returns the snapshot.
- R10: Writing a low half (2 or 4) only stages the data. Writing the matching high half (3 or 5) commits the staged low half and the new high half together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe, one cycle per half-word |
| busRe | input | 1 | Read strobe, one cycle per half-word |
| busAddr | input | 3 | Half-word address |
| busWdata | input | busW | Write data |
| busRdata | output | busW | Read data, valid while `busRe` is high, zero otherwise |
| timerIn | input | 1 | Asynchronous timer pin input for capture and counting |
| altClkIn | input | 1 | Asynchronous alternate clock for generation mode |
| timerOut | output | 1 | Generated pulse output |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the two different restart points, period match in generation and event counting versus the leading edge in capture. A design that mixed these up would show pulses one clock too long, or event counts off by one, against the reference. It reads a high half hundreds of cycles after its low half while the counter runs across a half boundary. A design without the snapshot would return a value torn from two different moments. The bench also writes a lone low half and a lone counter half and reads them back, which exposes premature commits and a writable counter. A run of more than 65 thousand clocks with no input edges drives the counter through its wrap. A missing or non-sticky overflow flag, or a W1C write that clears the wrong bit, shows up there on `irq` and the status read.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_GEN = 2'd1,
    MODE_CAP = 2'd2,
    MODE_CNT = 2'd3
  } modeT;

  typedef struct packed {
    logic en;
    modeT mode;
    logic edgeSel;
    logic altClk;
  } cfgT;

  typedef struct packed {
    logic start;
    logic loadOne;
    logic wrPeriod;
    logic wrWidth;
  } strobeT;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_STAT   = 3'd1;
  localparam logic [2:0] A_PER_LO = 3'd2;
  localparam logic [2:0] A_PER_HI = 3'd3;
  localparam logic [2:0] A_WID_LO = 3'd4;
  localparam logic [2:0] A_WID_HI = 3'd5;
  localparam logic [2:0] A_CNT_LO = 3'd6;
  localparam logic [2:0] A_CNT_HI = 3'd7;

  localparam int CTRL_W = 6;

endpackage

// File: rtl/gpt_edge_sync.sv
module gpt_edge_sync #(
  parameter int stages = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic rise,
  output logic fall
);
  // shiftQ[stages-1] is the synchronised level, shiftQ[stages] its previous value
  logic [stages:0] shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[stages-1:0], pinIn};
  end

  assign rise = shiftQ[stages-1] & ~shiftQ[stages];
  assign fall = ~shiftQ[stages-1] & shiftQ[stages];
endmodule

// File: rtl/gpt_datapath.sv
module gpt_datapath import gpt_pkg::*; #(
  parameter int cntW = 32,
  parameter int syncStages = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  cfgT             cfg,
  input  strobeT          strb,
  input  logic [cntW-1:0] wrData,
  input  logic            timerIn,
  input  logic            altClkIn,
  output logic [cntW-1:0] cntQ,
  output logic [cntW-1:0] periodQ,
  output logic [cntW-1:0] widthQ,
  output logic            evtReset,
  output logic            evtOvf,
  output logic            timerOut
);
  localparam logic [cntW-1:0] ONE = cntW'(1);
  localparam logic [cntW-1:0] MAX = '1;

  logic pinRise, pinFall, altRise, altFall;
  logic leadEdge, trailEdge, active, tick, capPer, capWid;
  logic [cntW-1:0] cntNext, cntInc;

  // one synchroniser per asynchronous input
  for (genvar g = 0; g < 2; g++) begin : gSync
    if (g == 0) begin : gPin
      gpt_edge_sync #(.stages(syncStages)) uSync (
        .clk(clk), .rstN(rstN), .pinIn(timerIn), .rise(pinRise), .fall(pinFall));
    end else begin : gAlt
      gpt_edge_sync #(.stages(syncStages)) uSync (
        .clk(clk), .rstN(rstN), .pinIn(altClkIn), .rise(altRise), .fall(altFall));
    end
  end

  always_comb begin
    leadEdge  = cfg.edgeSel ? pinFall : pinRise;
    trailEdge = cfg.edgeSel ? pinRise : pinFall;
    active    = cfg.en && (cfg.mode != MODE_OFF);
    cntInc    = cntQ + ONE;
    unique case (cfg.mode)
      MODE_GEN: tick = cfg.altClk ? (altRise & ~altFall) : 1'b1;
      MODE_CAP: tick = 1'b1;
      MODE_CNT: tick = leadEdge;
      default:  tick = 1'b0;
    endcase
  end

  always_comb begin
    cntNext  = cntQ;
    evtReset = 1'b0;
    evtOvf   = 1'b0;
    capPer   = 1'b0;
    capWid   = 1'b0;
    if (strb.start) begin
      cntNext = strb.loadOne ? ONE : '0;
    end else if (active) begin
      if (cfg.mode == MODE_CAP && leadEdge) begin
        capPer   = 1'b1;
        cntNext  = ONE;
        evtReset = 1'b1;
      end else if (tick) begin
        if (cfg.mode == MODE_GEN && cntQ == periodQ) begin
          cntNext  = ONE;
          evtReset = 1'b1;
        end else if (cfg.mode == MODE_CNT && cntInc == periodQ) begin
          cntNext  = '0;
          evtReset = 1'b1;
        end else if (cntQ == MAX) begin
          cntNext = '0;
          evtOvf  = 1'b1;
        end else begin
          cntNext = cntInc;
        end
      end
      capWid = (cfg.mode == MODE_CAP) && trailEdge;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      periodQ <= '0;
      widthQ  <= '0;
    end else begin
      cntQ <= cntNext;
      if (capPer)             periodQ <= cntQ;
      else if (strb.wrPeriod) periodQ <= wrData;
      if (capWid)             widthQ  <= cntQ;
      else if (strb.wrWidth)  widthQ  <= wrData;
    end
  end

  assign timerOut = active && (cfg.mode == MODE_GEN) && (cntQ <= widthQ);
endmodule

// File: rtl/gpt_ctrl.sv
module gpt_ctrl import gpt_pkg::*; #(
  parameter int busW = 16,
  localparam int cntW = 2 * busW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busWe,
  input  logic            busRe,
  input  logic [2:0]      busAddr,
  input  logic [busW-1:0] busWdata,
  output logic [busW-1:0] busRdata,
  input  logic [cntW-1:0] cntIn,
  input  logic [cntW-1:0] periodIn,
  input  logic [cntW-1:0] widthIn,
  input  logic            evtReset,
  input  logic            evtOvf,
  output cfgT             cfg,
  output strobeT          strb,
  output logic [cntW-1:0] wrData,
  output logic [1:0]      flags,
  output logic            irq
);
  logic [CTRL_W-1:0] ctrlQ;
  logic              intFlag, ovfFlag;
  logic [busW-1:0]   stashQ, shadowQ;
  logic              wrCtrl, wrStat;

  assign wrCtrl = busWe && (busAddr == A_CTRL);
  assign wrStat = busWe && (busAddr == A_STAT);

  always_comb begin
    cfg.en      = ctrlQ[0];
    cfg.mode    = modeT'(ctrlQ[2:1]);
    cfg.edgeSel = ctrlQ[4];
    cfg.altClk  = ctrlQ[5];
    strb.start    = wrCtrl && busWdata[0] && !ctrlQ[0];
    strb.loadOne  = modeT'(busWdata[2:1]) == MODE_GEN;
    strb.wrPeriod = busWe && (busAddr == A_PER_HI);
    strb.wrWidth  = busWe && (busAddr == A_WID_HI);
    wrData        = {busWdata, stashQ};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      intFlag <= 1'b0;
      ovfFlag <= 1'b0;
      stashQ  <= '0;
      shadowQ <= '0;
    end else begin
      if (wrCtrl) ctrlQ <= busWdata[CTRL_W-1:0];
      if (busWe && (busAddr == A_PER_LO || busAddr == A_WID_LO)) stashQ <= busWdata;
      intFlag <= evtReset | (intFlag & ~(wrStat & busWdata[0]));
      ovfFlag <= evtOvf   | (ovfFlag & ~(wrStat & busWdata[1]));
      if (busRe) begin
        case (busAddr)
          A_PER_LO: shadowQ <= periodIn[cntW-1:busW];
          A_WID_LO: shadowQ <= widthIn[cntW-1:busW];
          A_CNT_LO: shadowQ <= cntIn[cntW-1:busW];
          default:  shadowQ <= shadowQ;
        endcase
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRe) begin
      case (busAddr)
        A_CTRL:   busRdata = {{(busW-CTRL_W){1'b0}}, ctrlQ};
        A_STAT:   busRdata = {{(busW-2){1'b0}}, ovfFlag, intFlag};
        A_PER_LO: busRdata = periodIn[busW-1:0];
        A_WID_LO: busRdata = widthIn[busW-1:0];
        A_CNT_LO: busRdata = cntIn[busW-1:0];
        default:  busRdata = shadowQ;
      endcase
    end
  end

  assign flags = {ovfFlag, intFlag};
  assign irq   = ctrlQ[3] && (intFlag || ovfFlag);
endmodule

// File: rtl/gp_timer.sv
module gp_timer import gpt_pkg::*; #(
  parameter int busW = 16,
  parameter int syncStages = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busWe,
  input  logic            busRe,
  input  logic [2:0]      busAddr,
  input  logic [busW-1:0] busWdata,
  output logic [busW-1:0] busRdata,
  input  logic            timerIn,
  input  logic            altClkIn,
  output logic            timerOut,
  output logic            irq
);
  localparam int cntW = 2 * busW;

  cfgT             cfg;
  strobeT          strb;
  logic [cntW-1:0] wrData, cntQ, periodQ, widthQ;
  logic            evtReset, evtOvf;
  logic [1:0]      flags;

  gpt_ctrl #(.busW(busW)) uCtrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cntIn(cntQ), .periodIn(periodQ),
    .widthIn(widthQ), .evtReset(evtReset), .evtOvf(evtOvf), .cfg(cfg),
    .strb(strb), .wrData(wrData), .flags(flags), .irq(irq));

  gpt_datapath #(.cntW(cntW), .syncStages(syncStages)) uData (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .wrData(wrData),
    .timerIn(timerIn), .altClkIn(altClkIn), .cntQ(cntQ), .periodQ(periodQ),
    .widthQ(widthQ), .evtReset(evtReset), .evtOvf(evtOvf), .timerOut(timerOut));
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
  parameter int cntW = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            busWe,
  input logic [2:0]      busAddr,
  input logic            start,
  input logic            loadOne,
  input logic            enNow,
  input logic [1:0]      modeNow,
  input logic [cntW-1:0] cntQ,
  input logic [cntW-1:0] periodQ,
  input logic            evtReset,
  input logic            evtOvf,
  input logic [1:0]      flags,
  input logic            timerOut
);
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (cntQ == (($past(loadOne)) ? cntW'(1) : cntW'(0)))); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !evtReset && !evtOvf) |=>
      (cntQ == $past(cntQ) || cntQ == $past(cntQ) + cntW'(1))); // R2

  AST_OUT_GEN_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    timerOut |-> (enNow && modeNow == 2'd1)); // R3

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    evtOvf |=> (cntQ == '0 && flags[1])); // R6

  AST_EVT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    evtReset |=> flags[0]); // R7

  AST_LO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 3'd2 && modeNow != 2'd2) |=> $stable(periodQ)); // R10
endmodule

bind gp_timer gpt_checker #(.cntW(cntW)) uChk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .start(strb.start), .loadOne(strb.loadOne), .enNow(cfg.en),
  .modeNow(cfg.mode), .cntQ(cntQ), .periodQ(periodQ), .evtReset(evtReset),
  .evtOvf(evtOvf), .flags(flags), .timerOut(timerOut));

// File: tb/gp_timer_test.sv
module gp_timer_test;
  localparam int CLK_P = 10;
  localparam int BW = 8;
  localparam int CW = 2 * BW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [2:0] busAddr = '0;
  logic [BW-1:0] busWdata = '0;
  logic [BW-1:0] busRdata;
  logic timerIn = 1'b0, altClkIn = 1'b0;
  logic timerOut, irq;

  int nChecks = 0;
  int nFail = 0;
  string curReq = "R1";

  always #(CLK_P/2) clk = ~clk;

  gp_timer #(.busW(BW)) uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .timerIn(timerIn),
    .altClkIn(altClkIn), .timerOut(timerOut), .irq(irq));

  // ---------------- behavioural reference ----------------
  logic [5:0]    mCtrl;
  logic [CW-1:0] mCnt, mPer, mWid;
  logic          mInt, mOvf;
  logic [BW-1:0] mStash, mShadow;
  logic          pinHist[$];
  logic          altHist[$];

  task automatic modelReset();
    mCtrl = '0; mCnt = '0; mPer = '0; mWid = '0;
    mInt = 1'b0; mOvf = 1'b0; mStash = '0; mShadow = '0;
    pinHist = '{1'b0, 1'b0, 1'b0};
    altHist = '{1'b0, 1'b0, 1'b0};
  endtask

  task automatic modelStep();
    logic [CW-1:0] nCnt, nPer, nWid, inc;
    logic [1:0] md;
    logic evt, ovf, pr, pf, ar, lead, trail, act, go;
    nCnt = mCnt; nPer = mPer; nWid = mWid; evt = 1'b0; ovf = 1'b0;
    inc = mCnt + 1'b1;
    pr = pinHist[1] && !pinHist[2];
    pf = !pinHist[1] && pinHist[2];
    ar = altHist[1] && !altHist[2];
    md = mCtrl[2:1];
    act = mCtrl[0] && (md != 2'd0);
    lead = mCtrl[4] ? pf : pr;
    trail = mCtrl[4] ? pr : pf;
    if (busWe && busAddr == 3'd3) nPer = {busWdata, mStash};
    if (busWe && busAddr == 3'd5) nWid = {busWdata, mStash};
    if (busWe && busAddr == 3'd0 && busWdata[0] && !mCtrl[0]) begin
      nCnt = (busWdata[2:1] == 2'd1) ? CW'(1) : CW'(0);
    end else if (act) begin
      if (md == 2'd2 && lead) begin
        nPer = mCnt; nCnt = CW'(1); evt = 1'b1;
      end else begin
        go = (md == 2'd2) || (md == 2'd1 && (!mCtrl[5] || ar)) || (md == 2'd3 && lead);
        if (go) begin
          if (md == 2'd1 && mCnt == mPer) begin nCnt = CW'(1); evt = 1'b1; end
          else if (md == 2'd3 && inc == mPer) begin nCnt = '0; evt = 1'b1; end
          else if (mCnt == '1) begin nCnt = '0; ovf = 1'b1; end
          else nCnt = inc;
        end
      end
      if (md == 2'd2 && trail) nWid = mCnt;
    end
    if (busRe && busAddr == 3'd2) mShadow = mPer[CW-1:BW];
    if (busRe && busAddr == 3'd4) mShadow = mWid[CW-1:BW];
    if (busRe && busAddr == 3'd6) mShadow = mCnt[CW-1:BW];
    if (busWe && (busAddr == 3'd2 || busAddr == 3'd4)) mStash = busWdata;
    mInt = evt || (mInt && !(busWe && busAddr == 3'd1 && busWdata[0]));
    mOvf = ovf || (mOvf && !(busWe && busAddr == 3'd1 && busWdata[1]));
    if (busWe && busAddr == 3'd0) mCtrl = busWdata[5:0];
    mCnt = nCnt; mPer = nPer; mWid = nWid;
    pinHist.push_front(timerIn); void'(pinHist.pop_back());
    altHist.push_front(altClkIn); void'(altHist.pop_back());
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else modelStep();
  end

  function automatic logic [BW-1:0] expRead();
    if (!busRe) return '0;
    case (busAddr)
      3'd0: return BW'(mCtrl);
      3'd1: return BW'({mOvf, mInt});
      3'd2: return mPer[BW-1:0];
      3'd4: return mWid[BW-1:0];
      3'd6: return mCnt[BW-1:0];
      default: return mShadow;
    endcase
  endfunction

  task automatic checkOne(string what, logic [BW-1:0] got, logic [BW-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %h expected %h at %0t", curReq, what, got, exp, $time);
    end
  endtask

  // compare every cycle, one step after the falling edge where inputs change
  always @(negedge clk) begin
    #1;
    checkOne("timerOut", BW'(timerOut),
             BW'(mCtrl[0] && mCtrl[2:1] == 2'd1 && mCnt <= mWid));
    checkOne("irq", BW'(irq), BW'(mCtrl[3] && (mInt || mOvf)));
    checkOne("busRdata", busRdata, expRead());
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(logic [2:0] a, logic [BW-1:0] d);
    @(negedge clk); busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(logic [2:0] a);
    @(negedge clk); busRe = 1'b1; busAddr = a;
    @(negedge clk); busRe = 1'b0;
  endtask

  task automatic write32(logic [2:0] lo, logic [CW-1:0] v);
    busWrite(lo, v[BW-1:0]);
    busWrite(lo + 3'd1, v[CW-1:BW]);
  endtask

  task automatic pinPulse(int hi, int lo);
    @(negedge clk); timerIn = 1'b1; idle(hi);
    timerIn = 1'b0; idle(lo);
  endtask

  task automatic dumpAll();
    for (int a = 0; a < 8; a++) busRead(3'(a));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    #(CLK_P * 200000);
    nFail++;
    $display("FAIL all watchdog expired");
    summary();
    $finish;
  end

  initial begin
    curReq = "R1";
    idle(4);
    rstN = 1'b1;
    dumpAll();

    curReq = "R10";
    busWrite(3'd2, 8'h34);
    busRead(3'd2);
    busRead(3'd3);
    busWrite(3'd3, 8'h12);
    busRead(3'd2);
    busRead(3'd3);
    write32(3'd4, 16'h0A0B);
    dumpAll();

    curReq = "R3";
    write32(3'd2, 16'd6);
    write32(3'd4, 16'd2);
    curReq = "R2";
    busWrite(3'd0, 8'h0B);
    curReq = "R3";
    idle(25);
    curReq = "R7";
    busWrite(3'd1, 8'h01);
    busRead(3'd1);
    busWrite(3'd0, 8'h00);
    curReq = "R3";
    busWrite(3'd0, 8'h2B);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); altClkIn = ~altClkIn; idle(2);
    end
    busWrite(3'd0, 8'h00);
    busWrite(3'd1, 8'h03);

    curReq = "R4";
    busWrite(3'd0, 8'h0D);
    for (int i = 0; i < 4; i++) pinPulse(4, 7);
    dumpAll();
    busWrite(3'd0, 8'h00);
    curReq = "R8";
    busWrite(3'd0, 8'h1D);
    @(negedge clk); timerIn = 1'b1; idle(5);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); timerIn = 1'b0; idle(3);
      timerIn = 1'b1; idle(6);
    end
    curReq = "R4";
    dumpAll();
    @(negedge clk); timerIn = 1'b0;
    busWrite(3'd0, 8'h00);
    busWrite(3'd1, 8'h03);

    curReq = "R5";
    write32(3'd2, 16'd4);
    busWrite(3'd0, 8'h0F);
    for (int i = 0; i < 10; i++) pinPulse(3, 3);
    busRead(3'd6);
    busWrite(3'd0, 8'h00);
    busWrite(3'd0, 8'h1F);
    for (int i = 0; i < 9; i++) pinPulse(2, 4);
    busRead(3'd6);
    busWrite(3'd0, 8'h00);
    busWrite(3'd1, 8'h03);

    curReq = "R9";
    busWrite(3'd0, 8'h0D);
    idle(300);
    busRead(3'd6);
    idle(300);
    busRead(3'd7);
    busRead(3'd6);
    busRead(3'd7);

    curReq = "R6";
    idle(65300);
    busRead(3'd1);
    curReq = "R7";
    busWrite(3'd1, 8'h01);
    busRead(3'd1);
    busWrite(3'd1, 8'h02);
    busRead(3'd1);

    curReq = "R2";
    write32(3'd6, 16'hBEEF);
    busRead(3'd6);
    busRead(3'd7);
    busWrite(3'd0, 8'h00);
    dumpAll();

    idle(4);
    summary();
    $finish;
  end
endmodule